// File: doc/BRIEF.md
# Edge and Gate Pulse Accumulator

The block counts activity on one external pin. In event mode every transition of the selected polarity adds one to a 16-bit count. In gated mode the pin acts as a gate: while the pin sits at its active level, each pulse on a prescaled tick input adds one. The pin is synchronised through two flops before any edge is detected. A split setting divides the count into two 8-bit halves. The low half keeps counting pin activity. The high half counts strobes from a separate capture-edge input, and an optional saturate setting makes the high half stop at its maximum value.

Two sticky flags record events. The input-edge flag records a qualifying edge on the pin. The overflow flag records a wrap of the count. Software reads and writes the count and the flags through a small register port. A flag is cleared either by writing a one to it or, when fast clearing is enabled, by any access to the count. The interrupt output combines each flag with its own enable.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count reads 0, both flags read 0 and irq is low. Address 0 selects the count and address 1 selects the flags. In the flag register, bit 0 is the input-edge flag and bit 1 is the overflow flag. Upper bits read as zero.
- R2: With fast clearing off, a write to address 1 clears each flag whose data bit is 1 and leaves alone each flag whose data bit is 0.
- R3: In 16-bit mode, an increment that takes the count from 0xFFFF to 0x0000 sets the overflow flag.
- R4: In split mode, count bits 15:8 advance on each cap_edge strobe, and a wrap of these bits from 0xFF to 0x00 sets the overflow flag. Count bits 7:0 advance on pin activity, wrap without carry and never set the overflow flag. In 16-bit mode cap_edge has no effect.
- R5: In split mode with saturate on, a cap_edge strobe while bits 15:8 equal 0xFF leaves them at 0xFF and sets the overflow flag.
- R6: In event mode, the edge selected by edge_pol (1 = rising, 0 = falling) increments the count and sets the input-edge flag. A pin change takes effect on the third rising clock edge after it is applied.
- R7: In gated mode, the count advances once per tick pulse while the synchronised pin equals edge_pol, which gives the active level. The input-edge flag sets only on the trailing edge, the change from the active level to the inactive level.
- R8: With fast clearing on, writes to address 1 leave both flags unchanged. A read strobe or a write strobe at address 0 clears both flags.
- R9: irq is high exactly when (overflow flag AND ovf_ie) OR (input-edge flag AND edge_ie).
- R10: When a flag's set event and a clear of that flag fall in the same cycle, the flag ends up set.
- R11: A write to address 0 loads the count with the write data. This load takes precedence over any increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used by fast clearing) |
| reg_addr | input | 1 | 0 = count, 1 = flags |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| acc_pin | input | 1 | Event or gate pin, asynchronous |
| cap_edge | input | 1 | Capture-edge strobe for the high half |
| tick | input | 1 | Prescaled clock tick for gated mode |
| mode_gated | input | 1 | 1 = gated time accumulation, 0 = event counting |
| edge_pol | input | 1 | Edge polarity or gate active level |
| split_mode | input | 1 | 1 = two 8-bit halves |
| sat_mode | input | 1 | 1 = high half saturates at 0xFF |
| fast_clr | input | 1 | 1 = flags cleared by a count access |
| ovf_ie | input | 1 | Overflow interrupt enable |
| edge_ie | input | 1 | Input-edge interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The counting function is driven with the following stimulus, each aimed at one part of the block:
- Rising pulse trains and falling pulse trains check that only the selected polarity counts.
- A held gate under a continuous tick checks the per-tick gated count and that only the trailing edge flags.
- Loads near 0xFFFF separate a true 16-bit wrap from the split low half, which wraps silently.
- Capture strobes at 0xFF in the high half separate wrapping from saturating.
- A pin edge timed to land in the same cycle as a count load, and another timed to land in the same cycle as a write-one clear, expose the precedence rules that a sequential test would miss.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  typedef enum logic {
    ADDR_COUNT = 1'b0,
    ADDR_FLAGS = 1'b1
  } pacc_addr_e;

  localparam int FLG_N    = 2;
  localparam int FLG_EDGE = 0;
  localparam int FLG_OVF  = 1;

  // Picks the rising or falling strobe by polarity.
  function automatic logic pick_edge(logic pol, logic rise, logic fall);
    return pol ? rise : fall;
  endfunction

endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;
  logic            prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign level = sh[STAGES-1];
  assign prev  = sh[STAGES];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             split,
  input  logic             sat,
  input  logic             inc_lo,
  input  logic             inc_hi,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt
);
  localparam int HW = CNT_W / 2;

  // Full-width step; the top bit is the wrap-out.
  function automatic logic [CNT_W:0] step_full(logic [CNT_W-1:0] v, logic en);
    logic [CNT_W:0] r;
    r = {1'b0, v};
    if (en) r = r + (CNT_W+1)'(1);
    return r;
  endfunction

  // Half step; the top bit flags a wrap (or a saturated hit when hold is set).
  function automatic logic [HW:0] step_half(logic [HW-1:0] v, logic en, logic hold);
    logic [HW:0] r;
    if (!en)       r = {1'b0, v};
    else if (&v)   r = hold ? {1'b1, v} : {1'b1, {HW{1'b0}}};
    else           r = {1'b0, v + HW'(1)};
    return r;
  endfunction

  logic [CNT_W:0]   full_nx;
  logic [HW:0]      lo_nx;
  logic [HW:0]      hi_nx;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    full_nx = step_full(count, inc_lo);
    lo_nx   = step_half(count[HW-1:0], inc_lo, 1'b0);
    hi_nx   = step_half(count[CNT_W-1:HW], inc_hi, sat);
    if (ld)         cnt_nx = ld_val;
    else if (split) cnt_nx = {hi_nx[HW-1:0], lo_nx[HW-1:0]};
    else            cnt_nx = full_nx[CNT_W-1:0];
    wrap_evt = ~ld & (split ? hi_nx[HW] : full_nx[CNT_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_nx;
  end
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             acc_pin,
  input  logic             cap_edge,
  input  logic             tick,
  input  logic             mode_gated,
  input  logic             edge_pol,
  input  logic             split_mode,
  input  logic             sat_mode,
  input  logic             fast_clr,
  input  logic             ovf_ie,
  input  logic             edge_ie,
  output logic             irq
);
  logic             pin_lvl, pin_rise, pin_fall;
  logic             act_edge, trail_edge, gate_on;
  logic             inc_evt, edg_evt, ovf_evt;
  logic             cnt_ld, cnt_touch, flg_wr;
  logic [FLG_N-1:0] flg_set, flg_clr, flags;
  logic [CNT_W-1:0] count;

  pacc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(acc_pin),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign act_edge   = pick_edge(edge_pol, pin_rise, pin_fall);
  assign trail_edge = pick_edge(~edge_pol, pin_rise, pin_fall);
  assign gate_on    = (pin_lvl == edge_pol);
  assign inc_evt    = mode_gated ? (gate_on & tick) : act_edge;
  assign edg_evt    = mode_gated ? trail_edge : act_edge;

  assign cnt_ld    = reg_wr & (reg_addr == ADDR_COUNT);
  assign cnt_touch = (reg_wr | reg_rd) & (reg_addr == ADDR_COUNT);
  assign flg_wr    = reg_wr & (reg_addr == ADDR_FLAGS) & ~fast_clr;

  pacc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(cnt_ld), .ld_val(reg_wdata),
    .split(split_mode), .sat(sat_mode),
    .inc_lo(inc_evt), .inc_hi(split_mode & cap_edge),
    .count(count), .wrap_evt(ovf_evt)
  );

  always_comb begin
    flg_set           = '0;
    flg_set[FLG_EDGE] = edg_evt;
    flg_set[FLG_OVF]  = ovf_evt;
    flg_clr = (flg_wr ? reg_wdata[FLG_N-1:0] : '0) | {FLG_N{fast_clr & cnt_touch}};
  end

  pacc_flags #(.N(FLG_N)) u_flg (
    .clk(clk), .rst_n(rst_n), .set(flg_set), .clr(flg_clr), .flags(flags)
  );

  assign irq = (flags[FLG_OVF] & ovf_ie) | (flags[FLG_EDGE] & edge_ie);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_COUNT) reg_rdata = count;
    else                        reg_rdata[FLG_N-1:0] = flags;
  end
endmodule

// File: rtl/pacc_checks.sv
module pacc_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             fast_clr,
  input logic             split_mode,
  input logic             sat_mode,
  input logic             cap_edge,
  input logic             irq,
  input logic             inc_evt,
  input logic             edg_evt,
  input logic             ovf_evt,
  input logic             cnt_ld,
  input logic [1:0]       flags,
  input logic [CNT_W-1:0] count
);
  localparam int HW = CNT_W / 2;

  a_r2_w1c_edge: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr && !fast_clr && reg_wdata[0] && !edg_evt |=> !flags[0]);

  a_r10_edge_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    edg_evt |=> flags[0]);

  a_r10_ovf_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[1]);

  a_r8_fast_blocks_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clr && reg_wr && reg_addr && flags[1] |=> flags[1]);

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flags == 2'b00 |-> !irq);

  a_r3_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !split_mode && inc_evt && !cnt_ld && (&count) |=> (count == '0) && flags[1]);

  a_r5_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    split_mode && sat_mode && cap_edge && !cnt_ld && (&count[CNT_W-1:HW])
      |=> (&count[CNT_W-1:HW]) && flags[1]);

  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> count == $past(reg_wdata));
endmodule

bind pulse_accum pacc_checks #(.CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .fast_clr(fast_clr), .split_mode(split_mode),
  .sat_mode(sat_mode), .cap_edge(cap_edge), .irq(irq), .inc_evt(inc_evt),
  .edg_evt(edg_evt), .ovf_evt(ovf_evt), .cnt_ld(cnt_ld), .flags(flags),
  .count(count)
);

// File: tb/tb_pulse_accum.sv
`timescale 1ns/1ps
module tb_pulse_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        acc_pin = 0, cap_edge = 0, tick = 0;
  logic        mode_gated = 0, edge_pol = 1, split_mode = 0, sat_mode = 0;
  logic        fast_clr = 0, ovf_ie = 0, edge_ie = 0;
  logic        irq;

  always #2.5 clk = ~clk;

  pulse_accum dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_pin(acc_pin), .cap_edge(cap_edge), .tick(tick),
    .mode_gated(mode_gated), .edge_pol(edge_pol), .split_mode(split_mode),
    .sat_mode(sat_mode), .fast_clr(fast_clr), .ovf_ie(ovf_ie),
    .edge_ie(edge_ie), .irq(irq)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int pipe[$];
  int m_cnt = 0, m_ef = 0, m_of = 0;
  int s2, s3, up, dn, hit, gate, inc, eset, oset, clr, lo, hi;

  always @(posedge clk) begin
    if (!rst_n) begin
      pipe = '{0, 0, 0};
      m_cnt = 0; m_ef = 0; m_of = 0;
    end else begin
      s2 = pipe[1]; s3 = pipe[2];
      up = (s2 == 1 && s3 == 0); dn = (s2 == 0 && s3 == 1);
      hit  = edge_pol ? up : dn;
      gate = (s2 == int'(edge_pol));
      if (mode_gated) begin
        inc  = gate && tick;
        eset = edge_pol ? dn : up;
      end else begin
        inc = hit; eset = hit;
      end
      oset = 0;
      if (reg_wr && reg_addr == 0) m_cnt = reg_wdata;
      else if (!split_mode) begin
        if (inc) begin
          if (m_cnt == 65535) begin m_cnt = 0; oset = 1; end
          else m_cnt = m_cnt + 1;
        end
      end else begin
        lo = m_cnt % 256; hi = m_cnt / 256;
        if (inc) lo = (lo + 1) % 256;
        if (cap_edge) begin
          if (hi == 255) begin oset = 1; if (!sat_mode) hi = 0; end
          else hi = hi + 1;
        end
        m_cnt = hi * 256 + lo;
      end
      clr = 0;
      if (reg_wr && reg_addr == 1 && !fast_clr) clr = reg_wdata[1:0];
      if (fast_clr && (reg_wr || reg_rd) && reg_addr == 0) clr = 3;
      if (clr & 1) m_ef = 0;
      if (clr & 2) m_of = 0;
      if (eset) m_ef = 1;
      if (oset) m_of = 1;
      pipe.push_front(int'(acc_pin));
      void'(pipe.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " model read"}, reg_rdata, reg_addr ? (m_of * 2 + m_ef) : m_cnt);
      chk({cur_req, " model irq"}, irq, (m_of && ovf_ie) || (m_ef && edge_ie));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic idle(int n);
    repeat (n) step();
  endtask
  task automatic wr(logic a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
  endtask
  task automatic peek(string req, logic a, logic [15:0] exp);
    reg_addr = a; #0.5;
    chk(req, reg_rdata, exp);
  endtask
  task automatic pulse();
    acc_pin = 1; idle(2); acc_pin = 0; idle(2);
  endtask
  task automatic cap();
    cap_edge = 1; step(); cap_edge = 0; step();
  endtask

  task automatic run();
    idle(3); rst_n = 1;
    peek("R1 count after reset", 0, 16'h0);
    peek("R1 flags after reset", 1, 16'h0);
    chk("R1 irq after reset", irq, 0);

    cur_req = "R6";
    repeat (3) pulse();
    idle(3);
    peek("R6 rising count", 0, 16'd3);
    peek("R6 edge flag", 1, 16'h1);
    cur_req = "R4";
    cap(); idle(1);
    peek("R4 cap ignored in 16-bit mode", 0, 16'd3);

    cur_req = "R2";
    wr(1, 16'h2);
    peek("R2 zero bit leaves flag", 1, 16'h1);
    wr(1, 16'h1);
    peek("R2 one bit clears flag", 1, 16'h0);

    cur_req = "R6";
    edge_pol = 0;
    repeat (2) pulse();
    idle(3);
    peek("R6 falling count", 0, 16'd5);

    cur_req = "R3";
    wr(0, 16'hFFFE);
    peek("R11 load value", 0, 16'hFFFE);
    repeat (2) pulse();
    idle(3);
    peek("R3 wrap count", 0, 16'h0);
    peek("R3 overflow flag", 1, 16'h3);

    cur_req = "R9";
    ovf_ie = 1; #0.5; chk("R9 irq ovf enabled", irq, 1);
    ovf_ie = 0; #0.5; chk("R9 irq all disabled", irq, 0);
    edge_ie = 1; #0.5; chk("R9 irq edge enabled", irq, 1);
    edge_ie = 0; step();

    cur_req = "R8";
    fast_clr = 1;
    wr(1, 16'h3);
    peek("R8 w1c blocked", 1, 16'h3);
    reg_addr = 0; reg_rd = 1; step(); reg_rd = 0;
    peek("R8 count read clears", 1, 16'h0);
    fast_clr = 0;

    cur_req = "R11";
    wr(0, 16'h0100);
    edge_pol = 1;
    acc_pin = 1; step(); step();
    reg_addr = 0; reg_wdata = 16'h0200; reg_wr = 1; step(); reg_wr = 0;
    acc_pin = 0; idle(3);
    peek("R11 load beats increment", 0, 16'h0200);

    cur_req = "R10";
    wr(1, 16'h3);
    acc_pin = 1; step(); step();
    reg_addr = 1; reg_wdata = 16'h1; reg_wr = 1; step(); reg_wr = 0;
    peek("R10 set beats clear", 1, 16'h1);
    acc_pin = 0; idle(3);
    wr(1, 16'h3);

    cur_req = "R7";
    mode_gated = 1; edge_pol = 1; tick = 1;
    wr(0, 16'h0);
    idle(2);
    acc_pin = 1; idle(4);
    peek("R7 no flag on leading edge", 1, 16'h0);
    idle(2);
    acc_pin = 0; idle(4);
    peek("R7 gated tick count", 0, 16'd6);
    peek("R7 trailing edge flag", 1, 16'h1);
    wr(1, 16'h3); wr(0, 16'h0);
    acc_pin = 1;
    for (int i = 0; i < 8; i++) begin tick = ~tick; step(); end
    acc_pin = 0; idle(4);
    edge_pol = 0; idle(5);
    tick = 0; mode_gated = 0; edge_pol = 1; idle(3);

    cur_req = "R4";
    split_mode = 1;
    wr(1, 16'h3); wr(0, 16'hFE00);
    cap(); cap();
    peek("R4 high half wrap", 0, 16'h0000);
    peek("R4 high half overflow", 1, 16'h2);
    wr(1, 16'h3); wr(0, 16'h00FF);
    pulse(); idle(3);
    peek("R4 low half no carry", 0, 16'h0000);
    peek("R4 low half no overflow", 1, 16'h1);

    cur_req = "R5";
    sat_mode = 1;
    wr(1, 16'h3); wr(0, 16'hFF00);
    cap();
    peek("R5 saturate holds", 0, 16'hFF00);
    peek("R5 saturate overflow", 1, 16'h2);
    wr(1, 16'h2);
    cap();
    peek("R5 overflow again at max", 1, 16'h2);
    idle(2);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired, actual=running expected=done");
      end
    join_any
    disable fork;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule